// File: doc/BRIEF.md
# Fat-Tree Switch Routing Register Configurator

This block fills in the interval-routing registers of a single switch in a k-ary n-tree. It is given the switch's stage, its identifier (n-1 base-k digits) and a mode bit, and on a start pulse it steps through every one of the switch's 2k output ports. For each port it writes four registers, one per cycle, on a simple write bus: the interval lower bound, the interval upper bound, the compare mask and the port-preference vector. A one-cycle done pulse follows the last write.

Ports 0 to k-1 lead down the tree and ports k to 2k-1 lead up. A downward port covers the destinations whose higher digits match the switch's own identifier and whose digit at the switch's stage equals the port number. Upward ports can be set up in two ways. In adaptive mode they share one interval that wraps around the destination space and covers every destination the switch cannot reach going down. In deterministic mode each upward port compares only the destination digit at the switch's stage, matches one value of that digit, and gives way to every downward port.

Each digit takes r = log2(k) bits, and digit j sits at bit offset j·r of a destination. k must be a power of two.

Top module: `ftree_rcfg`

## Requirements
- R1: After reset, `wr_en_o`, `busy_o` and `done_o` are all low.
- R2: In the cycle after a start is accepted, `busy_o` goes high and `wr_en_o` stays high for exactly 8k consecutive cycles. Ports are written in order 0 to 2k-1, and each port gets its registers in the order `wr_sel_o` = 0 (lower bound), 1 (upper bound), 2 (mask), 3 (preference).
- R3: `done_o` is high for exactly one cycle, in the cycle after the last write, and `wr_en_o` and `busy_o` are low in that cycle.
- R4: A start pulse while busy is ignored. Changes to stage, identifier or mode while busy have no effect on the values being written, because these inputs are captured when start is accepted.
- R5: Downward port i: for every digit j above the stage s, destination digit j equals identifier digit j-1. Digit s equals i. The lower digits are all 0 in the lower bound and all k-1 in the upper bound.
- R6: A downward port always gets a mask of all ones (n·r bits) and a preference vector of zero.
- R7: In adaptive mode every upward port gets a lower bound of (upper bound of port k-1, plus 1) mod k^n and an upper bound of (lower bound of port 0, minus 1) mod k^n. The resulting interval may wrap around.
- R8: In adaptive mode every upward port gets a mask of all ones and a preference vector of zero.
- R9: In deterministic mode upward port L gets a mask whose ones are only on the r bits of digit s. Both of its bounds equal L-k placed at digit s, with zeros elsewhere.
- R10: In deterministic mode every upward port gets a preference vector (2k bits) with the low k bits set and the high k bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a configuration pass (sampled when idle) |
| stage_i | input | SW | Stage s of the switch |
| sw_id_i | input | (N-1)·r | Switch identifier digits, digit 0 in the low bits |
| det_mode_i | input | 1 | 1 = deterministic upward routing, 0 = adaptive |
| wr_en_o | output | 1 | Register write strobe |
| wr_port_o | output | log2(2k) | Port whose register is being written |
| wr_sel_o | output | 2 | Register select: 0 lower, 1 upper, 2 mask, 3 preference |
| wr_data_o | output | max(n·r, 2k) | Register value, zero-extended |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
After start is seen at a clock edge, the first write appears in the cycle after that edge. Each later write follows one cycle after the previous one, and done follows one cycle after the last write. The bench raises start half a period before an edge and then samples every output on each falling edge from the next one onward. It compares write w with the value it computes for port w/4, register w%4, using integer digit arithmetic. The done pulse is checked in the falling edge right after the final write, and its fall one cycle later. A second start, together with altered inputs, is driven in the middle of one pass, and the remaining writes of that pass must still match the values captured at the first start.

// File: rtl/ftree_rcfg.sv
module ftree_rcfg #(
  parameter int K = 4,
  parameter int N = 3,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [SW-1:0]                 stage_i,
  input  logic [(N-1)*$clog2(K)-1:0]    sw_id_i,
  input  logic                          det_mode_i,
  output logic                          wr_en_o,
  output logic [$clog2(2*K)-1:0]        wr_port_o,
  output logic [1:0]                    wr_sel_o,
  output logic [((N*$clog2(K)) > (2*K) ? N*$clog2(K) : 2*K)-1:0] wr_data_o,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int R   = $clog2(K);
  localparam int DW  = N * R;
  localparam int IW  = (N - 1) * R;
  localparam int NP  = 2 * K;
  localparam int PW  = $clog2(NP);
  localparam int WDW = (DW > NP) ? DW : NP;
  localparam int CW  = PW + 2;
  localparam logic [CW-1:0] LAST = CW'(4 * NP - 1);
  localparam logic [DW-1:0] DIGM = DW'((1 << R) - 1);
  localparam logic [NP-1:0] PREF = {{K{1'b0}}, {K{1'b1}}};

  logic [CW-1:0] cnt;
  logic [SW-1:0] st_q;
  logic [DW-1:0] ide;
  logic          det_q;
  logic [IW-1:0] id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
      st_q   <= '0;
      id_q   <= '0;
      det_q  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          cnt    <= '0;
          st_q   <= stage_i;
          id_q   <= sw_id_i;
          det_q  <= det_mode_i;
        end
      end else if (cnt == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ide       = {id_q, {R{1'b0}}};
  assign wr_en_o   = busy_o;
  assign wr_port_o = cnt[CW-1:2];
  assign wr_sel_o  = cnt[1:0];

  function automatic logic [DW-1:0] dn_bound(input logic [R-1:0] d, input logic hi,
                                             input logic [SW-1:0] s, input logic [DW-1:0] e);
    logic [DW-1:0] v;
    v = '0;
    for (int j = 0; j < N; j++) begin
      if (j > int'(s))       v[j*R +: R] = e[j*R +: R];
      else if (j == int'(s)) v[j*R +: R] = d;
      else                   v[j*R +: R] = {R{hi}};
    end
    return v;
  endfunction

  logic [R-1:0]  dig;
  logic          up;
  logic [DW-1:0] val;
  logic [DW-1:0] dmask;
  logic [DW-1:0] dval;

  assign dig   = wr_port_o[R-1:0];
  assign up    = wr_port_o[PW-1];
  assign dmask = DIGM << (int'(st_q) * R);
  assign dval  = DW'(dig) << (int'(st_q) * R);

  always_comb begin
    val = '0;
    unique case (wr_sel_o)
      2'd0: if (!up)       val = dn_bound(dig, 1'b0, st_q, ide);
            else if (det_q) val = dval;
            else           val = dn_bound({R{1'b1}}, 1'b1, st_q, ide) + 1'b1;
      2'd1: if (!up)       val = dn_bound(dig, 1'b1, st_q, ide);
            else if (det_q) val = dval;
            else           val = dn_bound({R{1'b0}}, 1'b0, st_q, ide) - 1'b1;
      2'd2: val = (up && det_q) ? dmask : {DW{1'b1}};
      default: val = '0;
    endcase
  end

  assign wr_data_o = (wr_sel_o == 2'd3) ? WDW'((up && det_q) ? PREF : '0) : WDW'(val);

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && $past(wr_en_o) |-> wr_sel_o == $past(wr_sel_o) + 2'd1); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o && $past(wr_en_o) && $past(wr_port_o) == PW'(NP - 1)); // R3
  AST_DOWN_PREF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && wr_sel_o == 2'd3 && !wr_port_o[PW-1] |-> wr_data_o == '0); // R6
  AST_DET_BOUNDS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && wr_sel_o == 2'd1 && wr_port_o[PW-1] && det_q |-> wr_data_o == $past(wr_data_o)); // R9
endmodule

// File: tb/ftree_rcfg_tb.sv
module ftree_rcfg_tb_top;
  localparam int K = 4;
  localparam int N = 3;
  localparam int R = 2;
  localparam int SW = 2;
  localparam int NP = 2 * K;
  localparam int KN = K ** N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] stage = '0;
  logic [(N-1)*R-1:0] id = '0;
  logic det = 1'b0;
  logic wr_en, busy, done;
  logic [2:0] port;
  logic [1:0] sel;
  logic [7:0] data;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ftree_rcfg #(.K(K), .N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stage_i(stage), .sw_id_i(id),
    .det_mode_i(det), .wr_en_o(wr_en), .wr_port_o(port), .wr_sel_o(sel),
    .wr_data_o(data), .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dn_base(int s, int sid, int i);
    int b = i * (K ** s);
    for (int j = s + 1; j < N; j++) b += ((sid / (K ** (j - 1))) % K) * (K ** j);
    return b;
  endfunction

  function automatic int expv(int s, int sid, bit m, int p, int r);
    int ps = K ** s;
    if (p < K) begin
      if (r == 0) return dn_base(s, sid, p);
      if (r == 1) return dn_base(s, sid, p) + ps - 1;
      if (r == 2) return KN - 1;
      return 0;
    end
    if (m) begin
      if (r <= 1) return (p - K) * ps;
      if (r == 2) return (K - 1) * ps;
      return (1 << K) - 1;
    end
    if (r == 0) return (dn_base(s, sid, K - 1) + ps) % KN;
    if (r == 1) return (dn_base(s, sid, 0) - 1 + KN) % KN;
    if (r == 2) return KN - 1;
    return 0;
  endfunction

  function automatic string tag(int p, bit m, int r);
    if (p < K) return (r <= 1) ? "R5" : "R6";
    if (m) return (r == 3) ? "R10" : "R9";
    return (r <= 1) ? "R7" : "R8";
  endfunction

  task automatic run_pass(input int s, input int sid, input bit m, input bit poke);
    @(negedge clk);
    stage = SW'(s); id = 4'(sid); det = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 4 * NP; w++) begin
      chk(wr_en && busy, "R2", int'(wr_en), 1);
      chk(int'(port) == w / 4 && int'(sel) == w % 4, "R2", int'(port) * 4 + int'(sel), w);
      chk(int'(data) == expv(s, sid, m, w / 4, w % 4), tag(w / 4, m, w % 4),
          int'(data), expv(s, sid, m, w / 4, w % 4));
      if (poke && w == 5) begin
        start = 1'b1; stage = SW'((s + 1) % N); id = ~id; det = ~m;
      end
      @(negedge clk);
      if (poke && w == 5) begin
        start = 1'b0;
        chk(int'(port) == 1 && int'(sel) == 2, "R4", int'(port) * 4 + int'(sel), 6);
      end
    end
    chk(done && !wr_en && !busy, "R3", int'(done), 1);
    @(negedge clk);
    chk(!done && !wr_en, "R3", int'(done), 0);
  endtask

  task automatic t_reset();
    #5;
    chk(!wr_en && !busy && !done, "R1", int'(wr_en) + int'(busy) + int'(done), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !busy && !done, "R1", int'(wr_en) + int'(busy) + int'(done), 0);
  endtask

  initial begin
    t_reset();
    run_pass(0, 0, 1'b0, 1'b0);   // R7 wrap at low end
    run_pass(1, 9, 1'b0, 1'b0);   // R5 R7 mid stage
    run_pass(2, 0, 1'b0, 1'b0);   // R7 top stage, full-range wrap
    run_pass(0, 14, 1'b1, 1'b0);  // R9 R10 stage 0
    run_pass(1, 6, 1'b1, 1'b1);   // R4 restart and input change ignored
    run_pass(2, 3, 1'b1, 1'b0);   // R9 top digit
    run_pass(0, 15, 1'b0, 1'b0);  // R7 wrap at high end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule